// File: doc/BRIEF.md
# Register-Mapped Byte-Wide SPI Master

This block is a single-peripheral SPI master that software drives through a small set of 32-bit registers on a simple bus-slave port. Each operation moves one byte in one direction only:
- A start-write command shifts the data register's low byte out on the serial output.
- A start-read command clocks one byte in from the serial input and deposits it in the data register.

Software polls a busy flag to learn when an operation has finished.

A configuration register selects:
- the bit order;
- the idle level of the serial clock;
- whether data is launched and sampled on rising or falling clock edges;
- a power-of-two divider for the serial clock, one code of which stops the clock.

The control register drives the chip select line directly and can place the data output in high impedance. Register reads are combinational on the address and have no side effects. A write takes effect at the clock edge on which `req_i` and `we_i` are high.

Top module: `spi_mm_master`

## Requirements
- R1: After reset, status reads 0x0, configuration reads 0x153 and control reads 0x9. So `cs_no`=1, `mosi_oe_o`=0 and `sclk_o`=1.
- R2: The status register is at offset 0x00, with busy in bit 0. Configuration is at 0x10 and control is at 0x14. Data is at 0x20: the low byte is writable, and bits above 7 read 0. Any other offset reads 0.
- R3: Writing control with bit 2 set while idle transmits the data byte on `mosi_o`: exactly 8 bits, one per sampling edge. After the transfer the data register still holds the transmitted byte.
- R4: Writing control with bit 1 set (bit 2 clear) while idle captures 8 bits from `miso_i`, one on each sampling edge. The data register then reads the captured byte, zero-extended. During a read, `mosi_o` stays 0.
- R5: A prescaler code p in configuration bits [2:0], with p from 0 to 6, gives an SPI clock period of 2^(p+1) system cycles, so busy stays high for 16·2^p cycles. Code 7 freezes `sclk_o` and the transfer holds busy until a running code is written.
- R6: Configuration bit 8 set sends and receives the MSB first. Clear, it uses LSB first.
- R7: Configuration bit 6 is the idle level of `sclk_o`, and `sclk_o` is back at that level after every transfer. A clear bit 5 samples on rising edges and a set bit 5 on falling edges. Bit 4 does the same for launch edges. The first bit is valid before the first sampling edge.
- R8: `cs_no` equals control bit 0: written 0 asserts the chip select, written 1 deasserts it.
- R9: `mosi_oe_o` is the inverse of control bit 3.
- R10: Start bits 1 and 2 always read back 0. Busy reads 1 in the cycle after an accepted start. A start written while busy is ignored. If both start bits are set, the write operation is the one performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write enable |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Read data, combinational on addr_i |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Serial data in |

## Verification
The assertions assume the following about software:
- Configuration is not rewritten while busy is set. The one exception is leaving the stop code 7, which a stalled transfer needs in order to resume.
- `miso_i` is stable around the system clock edges at which the serial clock changes.

The bench respects these assumptions:
- It programs configuration and data only while idle.
- It rewrites configuration mid-transfer only in the stopped-clock case.
- It changes `miso_i` only on the falling system clock edge that follows each observed sampling edge.

Injected start commands during a transfer always repeat the current chip-select and high-impedance bits, so they cannot disturb those outputs.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

  localparam int unsigned PRESC_W = 3;

  localparam int unsigned OFS_STAT = 'h00;
  localparam int unsigned OFS_CFG  = 'h10;
  localparam int unsigned OFS_CTL  = 'h14;
  localparam int unsigned OFS_DATA = 'h20;

  localparam int unsigned CFG_MSB = 8;
  localparam int unsigned CFG_POL = 6;
  localparam int unsigned CFG_RXF = 5;
  localparam int unsigned CFG_TXF = 4;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_RD  = 1;
  localparam int unsigned CTL_WR  = 2;
  localparam int unsigned CTL_HIZ = 3;

  localparam logic [PRESC_W-1:0] PRESC_OFF = '1;

  typedef struct packed {
    logic               msb_first;
    logic               pol;
    logic               rx_fall;
    logic               tx_fall;
    logic [PRESC_W-1:0] presc;
  } cfg_t;

  localparam cfg_t CFG_RST = '{msb_first: 1'b1, pol: 1'b1, rx_fall: 1'b0,
                               tx_fall: 1'b1, presc: PRESC_W'(3)};

endpackage

// File: rtl/spi_mm_regs.sv
module spi_mm_regs
  import spi_mm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              rx_valid_i,
  input  logic [WORD_W-1:0] rx_data_i,
  output cfg_t              cfg_o,
  output logic              cs_no,
  output logic              hiz_o,
  output logic              start_wr_o,
  output logic              start_rd_o,
  output logic [WORD_W-1:0] tx_data_o
);

  logic sel_stat, sel_cfg, sel_ctl, sel_data;
  logic wr_cfg, wr_ctl, wr_data;
  cfg_t cfg_q;
  logic en_q, hiz_q;
  logic [WORD_W-1:0] data_q;

  assign sel_stat = addr_i == ADDR_W'(OFS_STAT);
  assign sel_cfg  = addr_i == ADDR_W'(OFS_CFG);
  assign sel_ctl  = addr_i == ADDR_W'(OFS_CTL);
  assign sel_data = addr_i == ADDR_W'(OFS_DATA);

  assign wr_cfg  = req_i & we_i & sel_cfg;
  assign wr_ctl  = req_i & we_i & sel_ctl;
  assign wr_data = req_i & we_i & sel_data;

  // write start has priority over read start
  assign start_wr_o = wr_ctl & wdata_i[CTL_WR] & ~busy_i;
  assign start_rd_o = wr_ctl & wdata_i[CTL_RD] & ~wdata_i[CTL_WR] & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      en_q  <= 1'b1;
      hiz_q <= 1'b1;
    end else begin
      if (wr_cfg) begin
        cfg_q.msb_first <= wdata_i[CFG_MSB];
        cfg_q.pol       <= wdata_i[CFG_POL];
        cfg_q.rx_fall   <= wdata_i[CFG_RXF];
        cfg_q.tx_fall   <= wdata_i[CFG_TXF];
        cfg_q.presc     <= wdata_i[PRESC_W-1:0];
      end
      if (wr_ctl) begin
        en_q  <= wdata_i[CTL_EN];
        hiz_q <= wdata_i[CTL_HIZ];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         data_q <= '0;
    else if (rx_valid_i) data_q <= rx_data_i;
    else if (wr_data)    data_q <= wdata_i[WORD_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_stat) begin
      rdata_o[0] = busy_i;
    end else if (sel_cfg) begin
      rdata_o[CFG_MSB]       = cfg_q.msb_first;
      rdata_o[CFG_POL]       = cfg_q.pol;
      rdata_o[CFG_RXF]       = cfg_q.rx_fall;
      rdata_o[CFG_TXF]       = cfg_q.tx_fall;
      rdata_o[PRESC_W-1:0]   = cfg_q.presc;
    end else if (sel_ctl) begin
      rdata_o[CTL_EN]  = en_q;
      rdata_o[CTL_HIZ] = hiz_q;
    end else if (sel_data) begin
      rdata_o[WORD_W-1:0] = data_q;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[BUS_W-1:CFG_MSB+1], wdata_i[CFG_MSB-1]};

  assign cfg_o     = cfg_q;
  assign cs_no     = en_q;
  assign hiz_o     = hiz_q;
  assign tx_data_o = data_q;

endmodule

// File: rtl/spi_mm_clkdiv.sv
module spi_mm_clkdiv
  import spi_mm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);

  // half period is 2^presc cycles; largest running code is PRESC_OFF-1
  localparam int unsigned CNT_W = (1 << PRESC_W) - 2;

  logic [CNT_W-1:0] cnt_q, lim;
  logic             stopped;

  assign lim     = (CNT_W'(1) << presc_i) - CNT_W'(1);
  assign stopped = presc_i == PRESC_OFF;
  assign tick_o  = run_i & ~stopped & (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (stopped)        cnt_q <= cnt_q;
    else if (tick_o)         cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_wr_i,
  input  logic              start_rd_i,
  input  logic              tick_i,
  input  logic              msb_first_i,
  input  logic              pol_i,
  input  logic              rx_fall_i,
  input  logic              tx_fall_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              wr_mode_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_data_o
);

  localparam int unsigned EDGES = 2 * WORD_W;
  localparam int unsigned EC_W  = $clog2(EDGES);

  logic              busy_q, wr_q, ph_q, sampled_q;
  logic [EC_W-1:0]   ec_q;
  logic [WORD_W-1:0] tx_sr_q, rx_sr_q, rx_nxt, tx_nxt;
  logic              tick, fall_nxt, samp, launch, shift, last;

  assign tick     = tick_i & busy_q;
  // next clock level is pol ^ ~ph; falling edge when it becomes 0
  assign fall_nxt = ~(pol_i ^ ~ph_q);
  assign samp     = tick & (fall_nxt == rx_fall_i);
  assign launch   = tick & (fall_nxt == tx_fall_i);
  // a launch edge before the first sample keeps bit 0 on the line
  assign shift    = launch & (sampled_q | samp);
  assign last     = tick & (ec_q == EC_W'(EDGES - 1));

  assign rx_nxt = msb_first_i ? {rx_sr_q[WORD_W-2:0], miso_i}
                              : {miso_i, rx_sr_q[WORD_W-1:1]};
  assign tx_nxt = msb_first_i ? {tx_sr_q[WORD_W-2:0], 1'b0}
                              : {1'b0, tx_sr_q[WORD_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      wr_q      <= 1'b0;
      ph_q      <= 1'b0;
      sampled_q <= 1'b0;
      ec_q      <= '0;
      tx_sr_q   <= '0;
      rx_sr_q   <= '0;
    end else if (start_wr_i | start_rd_i) begin
      busy_q    <= 1'b1;
      wr_q      <= start_wr_i;
      ph_q      <= 1'b0;
      sampled_q <= 1'b0;
      ec_q      <= '0;
      tx_sr_q   <= tx_data_i;
      rx_sr_q   <= '0;
    end else if (tick) begin
      ph_q <= ~ph_q;
      ec_q <= ec_q + EC_W'(1);
      if (samp) begin
        rx_sr_q   <= rx_nxt;
        sampled_q <= 1'b1;
      end
      if (shift) tx_sr_q <= tx_nxt;
      if (last)  busy_q  <= 1'b0;
    end
  end

  assign busy_o     = busy_q;
  assign wr_mode_o  = wr_q;
  assign sclk_o     = pol_i ^ ph_q;
  assign mosi_o     = busy_q & wr_q & (msb_first_i ? tx_sr_q[WORD_W-1] : tx_sr_q[0]);
  assign rx_valid_o = last & ~wr_q;
  assign rx_data_o  = samp ? rx_nxt : rx_sr_q;

endmodule

// File: rtl/spi_mm_master.sv
module spi_mm_master
  import spi_mm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i
);

  cfg_t              cfg;
  logic              busy, wr_mode, hiz, start_wr, start_rd, tick, rx_valid;
  logic [WORD_W-1:0] tx_data, rx_data;

  spi_mm_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .WORD_W(WORD_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .busy_i     (busy),
    .rx_valid_i (rx_valid),
    .rx_data_i  (rx_data),
    .cfg_o      (cfg),
    .cs_no      (cs_no),
    .hiz_o      (hiz),
    .start_wr_o (start_wr),
    .start_rd_o (start_rd),
    .tx_data_o  (tx_data)
  );

  spi_mm_clkdiv u_clkdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy),
    .presc_i (cfg.presc),
    .tick_o  (tick)
  );

  spi_mm_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_wr_i  (start_wr),
    .start_rd_i  (start_rd),
    .tick_i      (tick),
    .msb_first_i (cfg.msb_first),
    .pol_i       (cfg.pol),
    .rx_fall_i   (cfg.rx_fall),
    .tx_fall_i   (cfg.tx_fall),
    .tx_data_i   (tx_data),
    .miso_i      (miso_i),
    .busy_o      (busy),
    .wr_mode_o   (wr_mode),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .rx_valid_o  (rx_valid),
    .rx_data_o   (rx_data)
  );

  assign mosi_oe_o = ~hiz;

endmodule

// File: rtl/spi_mm_checker.sv
module spi_mm_checker
  import spi_mm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [3:0]         wctl_i,
  input logic               sclk_o,
  input logic               cs_no,
  input logic               mosi_o,
  input logic               busy_i,
  input logic               wr_mode_i,
  input logic               pol_i,
  input logic [PRESC_W-1:0] presc_i
);

  logic ctl_wr;
  assign ctl_wr = req_i & we_i & (addr_i == ADDR_W'(OFS_CTL));

  a_r7_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sclk_o == pol_i);

  a_r8_cs_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> cs_no == $past(wctl_i[CTL_EN]));

  a_r8_cs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr |=> $stable(cs_no));

  a_r10_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && (wctl_i[CTL_WR] || wctl_i[CTL_RD]) |=> busy_i);

  a_r5_clock_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && presc_i == PRESC_OFF |=> $stable(sclk_o));

  a_r4_read_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !wr_mode_i |-> mosi_o == 1'b0);

endmodule

bind spi_mm_master spi_mm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wctl_i    (wdata_i[3:0]),
  .sclk_o    (sclk_o),
  .cs_no     (cs_no),
  .mosi_o    (mosi_o),
  .busy_i    (busy),
  .wr_mode_i (wr_mode),
  .pol_i     (cfg.pol),
  .presc_i   (cfg.presc)
);

// File: tb/spi_mm_master_tb.sv
`timescale 1ns/1ps
module spi_mm_master_tb_top;

  localparam logic [7:0] A_STAT = 8'h00, A_CFG = 8'h10, A_CTL = 8'h14, A_DATA = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, miso = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, cs_n, mosi, mosi_oe;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  spi_mm_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .cs_no(cs_n),
    .mosi_o(mosi), .mosi_oe_o(mosi_oe), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic bit_at(input logic [7:0] b, input logic msb, input int i);
    return msb ? b[7-i] : b[i];
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; addr = A_STAT;
    #1;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata; addr = A_STAT;
  endtask

  task automatic xfer(input logic [7:0] txb, input logic [7:0] rxb, input logic [2:0] presc,
                      input logic msb, input logic pol, input logic rxf, input logic txf,
                      input logic [3:0] ctl, input int inject);
    logic [31:0] r;
    logic [7:0]  got, expb;
    logic        prev_s, prev_m, quiet, is_wr, done;
    int          nsamp, bcnt;
    is_wr = ctl[2];
    bus_write(A_CFG, {23'b0, msb, 1'b0, pol, rxf, txf, 1'b0, presc});
    bus_write(A_DATA, {24'b0, txb});
    miso = bit_at(rxb, msb, 0);
    nsamp = 0; got = '0; quiet = 1; done = 0;
    bus_write(A_CTL, {28'b0, ctl});
    chk(rdata[0] == 1'b1, "R10 busy after start", rdata, 1);
    chk(sclk == pol, "R7 idle level at start", sclk, pol);
    chk(mosi_oe == ~ctl[3], "R9 output enable", mosi_oe, ~ctl[3]);
    chk(cs_n == ctl[0], "R8 chip select", cs_n, ctl[0]);
    prev_s = sclk; prev_m = mosi; bcnt = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (req) begin req = 0; we = 0; addr = A_STAT; end
      if (i == inject) begin req = 1; we = 1; addr = A_CTL; wdata = {28'b0, ctl | 4'b0110}; end
      #1;
      if (sclk != prev_s && (!sclk) == rxf) begin
        if (nsamp < 8) got[nsamp] = prev_m;
        nsamp++;
        if (nsamp < 8) miso = bit_at(rxb, msb, nsamp);
      end
      prev_s = sclk; prev_m = mosi;
      if (!is_wr && mosi) quiet = 0;
      if (i != inject && rdata[0] == 1'b0) begin done = 1; break; end
      bcnt++;
    end
    if (req) begin @(negedge clk); req = 0; we = 0; addr = A_STAT; end
    chk(done, "R5 transfer ends", done, 1);
    chk(bcnt == (16 << presc), "R5 busy length", bcnt, 16 << presc);
    chk(nsamp == 8, "R7 sampling edge count", nsamp, 8);
    chk(sclk == pol, "R7 idle level after", sclk, pol);
    bus_read(A_DATA, r);
    if (is_wr) begin
      for (int i = 0; i < 8; i++) expb[i] = bit_at(txb, msb, i);
      chk(got == expb, "R3/R6 serial stream", got, expb);
      chk(r == {24'b0, txb}, "R3 data kept", r, txb);
    end else begin
      chk(r == {24'b0, rxb}, "R4/R6 received byte", r, rxb);
      chk(quiet, "R4 mosi low in read", quiet, 1);
    end
    bus_read(A_CTL, r);
    chk(r == {28'b0, ctl[3], 2'b00, ctl[0]}, "R10 start bits read 0", r, {ctl[3], 2'b00, ctl[0]});
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [3:0]  c;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    bus_read(A_STAT, r); chk(r == 32'h0, "R1 status reset", r, 0);
    bus_read(A_CFG, r);  chk(r == 32'h153, "R1 config reset", r, 32'h153);
    bus_read(A_CTL, r);  chk(r == 32'h9, "R1 control reset", r, 9);
    chk(cs_n == 1 && mosi_oe == 0 && sclk == 1, "R1 pins reset", {cs_n, mosi_oe, sclk}, 3'b101);
    bus_read(8'h04, r); chk(r == 0, "R2 unmapped 0x04", r, 0);
    bus_read(8'h24, r); chk(r == 0, "R2 unmapped 0x24", r, 0);
    bus_write(A_DATA, 32'hFFFF_FFA5);
    bus_read(A_DATA, r); chk(r == 32'hA5, "R2 data width", r, 32'hA5);
    bus_write(A_CFG, 32'hFFFF_FFFF);
    bus_read(A_CFG, r); chk(r == 32'h177, "R2 config fields", r, 32'h177);
    bus_write(A_CTL, 32'h0);
    chk(cs_n == 0, "R8 cs asserted", cs_n, 0);
    bus_write(A_CTL, 32'h1);
    chk(cs_n == 1, "R8 cs released", cs_n, 1);
    chk(mosi_oe == 1, "R9 hiz cleared", mosi_oe, 1);

    // directed: all edge combinations, both orders
    for (int m = 0; m < 16; m++)
      xfer(8'hB4 ^ 8'(m), 8'h3C ^ 8'(m * 17), 3'd0, m[0], m[1], m[2], m[3], m[0] ? 4'b0100 : 4'b0010, -1);
    xfer(8'h81, 8'h00, 3'd6, 1, 0, 0, 1, 4'b0100, -1);          // R5 slowest rate
    xfer(8'h5A, 8'hC3, 3'd1, 1, 1, 0, 1, 4'b0110, -1);          // R10 both starts -> write
    xfer(8'h0F, 8'h96, 3'd1, 0, 0, 1, 0, 4'b0010, 3);           // R10 start during read ignored
    xfer(8'hE7, 8'h11, 3'd2, 1, 1, 1, 1, 4'b1100, 5);           // R10 start during write ignored, R9 hiz

    // R5 stopped clock
    bus_write(A_CFG, 32'h107);
    bus_write(A_DATA, 32'h55);
    bus_write(A_CTL, 32'h4);
    begin
      logic s0; bit stuck;
      s0 = sclk; stuck = 1;
      repeat (200) begin @(negedge clk); #1; if (sclk != s0 || rdata[0] != 1) stuck = 0; end
      chk(stuck, "R5 code 7 holds clock", stuck, 1);
    end
    bus_write(A_CFG, 32'h100);
    repeat (40) @(negedge clk);
    bus_read(A_STAT, r); chk(r == 0, "R5 resumes after code change", r, 0);

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [7:0] rv;
      rv = 8'($urandom);
      c = {rv[7], rv[0], ~rv[0], rv[6]};
      if (c[2]) c[1] = rv[5];
      xfer(8'($urandom), 8'($urandom), 3'($urandom % 4), rv[1], rv[2], rv[3], rv[4], c, -1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule